// File: doc/BRIEF.md
# Result Buffer with Drain Request Routing

This block holds conversion results between a result source and a bus-side reader. Each incoming 16-bit result is written into a four-slot circular register array. A bus read of the pop location returns the oldest stored result and removes it. The entries stay in their slots. Only a write index and a read index move.

The block reports its fill level, its read index, a not-empty flag and a sticky overflow flag. When draining is enabled and results are waiting, it raises a drain request. A select input steers that request to the interrupt line when low and to the DMA request line when high. Software or a DMA channel then answers the request by reading the pop location once per result.

The reset input is asserted asynchronously, and its release is synchronised to the clock through two flops.

Top module: `result_drain_fifo`

## Requirements
- R1: Results are returned in arrival order, and the buffer holds up to 4 entries of 16 bits.
- R2: An accepted push raises `fill_count` by one and moves the write index to the next slot. The write index wraps from 3 to 0.
- R3: A pop happens when `bus_rd` is high and at least one bit of `bus_be` is set, so byte-wide, halfword-wide and full-width reads all count. A pop removes exactly one entry and lowers `fill_count` by one.
  - `bus_be[0]` enables bits 7:0 of `bus_rdata`, and `bus_be[1]` enables bits 15:8.
  - A byte lane that is not enabled reads as zero.
- R4: `head_ptr` always shows the slot of the next entry a pop will return. It advances by one on each pop and wraps from 3 to 0.
- R5: `has_data` is high exactly when `fill_count` is nonzero.
- R6: A push that arrives while 4 entries are stored and no pop happens in the same cycle is discarded. It sets `overflow`, which then stays high.
- R7: A one-cycle pulse on `overflow_clr` clears `overflow`. If a discarded push happens in the same cycle, the set wins.
- R8: A read while the buffer is empty returns zero and leaves `fill_count` and `head_ptr` unchanged.
- R9: A push and a pop in the same cycle leave `fill_count` unchanged and advance both indices. This also holds when the buffer is full, in which case the push is kept.
- R10: A drain request (`irq_req` or `dma_req`) is high only when `drain_en` is high and the buffer is not empty.
- R11: With `drain_to_dma` at 0 the request appears on `irq_req`, and with 1 it appears on `dma_req`. The two outputs are never high together.
- R12: After reset, `fill_count` is 0 and `head_ptr` is 0. `has_data`, `overflow`, `irq_req` and `dma_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| res_valid | input | 1 | Incoming result strobe |
| res_data | input | 16 | Incoming result value |
| bus_rd | input | 1 | Bus read of the pop location |
| bus_be | input | 2 | Byte enables of that read |
| bus_rdata | output | 16 | Oldest entry, masked by the byte enables; zero when empty |
| overflow_clr | input | 1 | Write-one pulse that clears `overflow` |
| drain_en | input | 1 | Enables the drain request |
| drain_to_dma | input | 1 | Request routing select: 0 for interrupt, 1 for DMA |
| fill_count | output | 3 | Number of stored entries |
| head_ptr | output | 2 | Slot index of the next entry to pop |
| has_data | output | 1 | Buffer not empty |
| overflow | output | 1 | Sticky flag for a discarded push |
| irq_req | output | 1 | Drain request to the interrupt line |
| dma_req | output | 1 | Drain request to the DMA line |

## Verification
The hardest case to create from the ports is a push and a pop in the same cycle while the buffer is full. That case also has to be checked after both indices have wrapped, so that a stale slot would show up as a wrong value.

The vector table builds this state in order. It first wraps the write index with a partial drain, then fills the buffer to four entries and tries a discarded push. It then issues a combined push and pop. The final pops read back every slot in order, and the expected read index and value are checked after each step.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DATA_W = 16;
  localparam int unsigned RF_DEPTH  = 4;

  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } route_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  assign stage_d = 1'b1;
  assign out_d   = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_n_sync <= out_d;
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              slot_ce;
    logic [DATA_W-1:0] slot_d;

    assign slot_ce = wr_en && (wr_idx == PTR_W'(g));
    assign slot_d  = wr_data;

    always_ff @(posedge clk) begin
      if (slot_ce) begin
        slot_q[g] <= slot_d;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl #(
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_in,
  input  logic             pop_in,
  input  logic             ovf_clr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             not_empty,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_idx_q, wr_idx_d;
  logic [PTR_W-1:0] rd_idx_q, rd_idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             pop_ok, push_ok, push_drop;
  logic             state_ce;

  always_comb begin
    pop_ok    = pop_in && (cnt_q != '0);
    push_ok   = push_in && ((cnt_q != FULL_CNT) || pop_ok);
    push_drop = push_in && !push_ok;

    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    cnt_d    = cnt_q;

    if (push_ok) begin
      wr_idx_d = (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
    end
    if (pop_ok) begin
      rd_idx_d = (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
    end
    if (push_ok && !pop_ok) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_d = cnt_q - 1'b1;
    end

    ovf_d = ovf_q;
    if (push_drop) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end

    state_ce = push_ok || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
    end else if (state_ce) begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign wr_en     = push_ok;
  assign wr_idx    = wr_idx_q;
  assign rd_idx    = rd_idx_q;
  assign count     = cnt_q;
  assign not_empty = (cnt_q != '0);
  assign ovf       = ovf_q;

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_in && !push_in && cnt_q == '0) |=> ($stable(cnt_q) && $stable(rd_idx_q)));

  // R9
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_in && pop_in && cnt_q != '0) |=> $stable(cnt_q));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_in && !pop_in && cnt_q == FULL_CNT) |=> (ovf_q && $stable(wr_idx_q)));
endmodule

// File: rtl/rf_route.sv
module rf_route
  import rf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic not_empty,
  input  logic sel,
  output logic irq,
  output logic dma
);
  route_e route;
  logic   want;

  always_comb begin
    route = sel ? ROUTE_DMA : ROUTE_IRQ;
    want  = enable && not_empty;
    irq   = want && (route == ROUTE_IRQ);
    dma   = want && (route == ROUTE_DMA);
  end

  // R11
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, dma}));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || dma) |-> (enable && not_empty));
endmodule

// File: rtl/result_drain_fifo.sv
module result_drain_fifo
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned DEPTH  = RF_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              bus_rd,
  input  logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              overflow_clr,
  input  logic              drain_en,
  input  logic              drain_to_dma,
  output logic [CNT_W-1:0]  fill_count,
  output logic [PTR_W-1:0]  head_ptr,
  output logic              has_data,
  output logic              overflow,
  output logic              irq_req,
  output logic              dma_req
);
  logic              rst_n_s;
  logic              pop_req;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [PTR_W-1:0]  rd_idx;
  logic [DATA_W-1:0] head_data;

  rf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign pop_req = bus_rd && (|bus_be);

  rf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push_in   (res_valid),
    .pop_in    (pop_req),
    .ovf_clr   (overflow_clr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .count     (fill_count),
    .not_empty (has_data),
    .ovf       (overflow)
  );

  rf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (res_data),
    .rd_idx  (rd_idx),
    .rd_data (head_data)
  );

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign bus_rdata[b*8 +: 8] = (has_data && bus_be[b]) ? head_data[b*8 +: 8] : 8'h00;
  end

  rf_route u_route (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .enable    (drain_en),
    .not_empty (has_data),
    .sel       (drain_to_dma),
    .irq       (irq_req),
    .dma       (dma_req)
  );

  assign head_ptr = rd_idx;

  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    has_data == (fill_count != '0));

  // R4
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!pop_req) |=> $stable(head_ptr));
endmodule

// File: tb/test_result_drain_fifo.sv
module test_result_drain_fifo;
  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_data;
  logic        bus_rd;
  logic [1:0]  bus_be;
  logic [15:0] bus_rdata;
  logic        overflow_clr;
  logic        drain_en;
  logic        drain_to_dma;
  logic [2:0]  fill_count;
  logic [1:0]  head_ptr;
  logic        has_data;
  logic        overflow;
  logic        irq_req;
  logic        dma_req;

  int checks;
  int fails;
  int cycles;
  bit done;

  result_drain_fifo i_result_drain_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .res_data     (res_data),
    .bus_rd       (bus_rd),
    .bus_be       (bus_be),
    .bus_rdata    (bus_rdata),
    .overflow_clr (overflow_clr),
    .drain_en     (drain_en),
    .drain_to_dma (drain_to_dma),
    .fill_count   (fill_count),
    .head_ptr     (head_ptr),
    .has_data     (has_data),
    .overflow     (overflow),
    .irq_req      (irq_req),
    .dma_req      (dma_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: push, data, rd, be, expected read data, expected count, expected head index
  typedef struct packed {
    logic        push;
    logic [15:0] data;
    logic        rd;
    logic [1:0]  be;
    logic [15:0] exp_rd;
    logic [2:0]  exp_cnt;
    logic [1:0]  exp_ptr;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'hA001, 1'b0, 2'b00, 16'h0000, 3'd1, 2'd0},
    '{1'b1, 16'hB002, 1'b0, 2'b11, 16'hA001, 3'd2, 2'd0},
    '{1'b1, 16'hC003, 1'b1, 2'b11, 16'hA001, 3'd2, 2'd1},
    '{1'b0, 16'h0000, 1'b1, 2'b01, 16'h0002, 3'd1, 2'd2},
    '{1'b0, 16'h0000, 1'b1, 2'b10, 16'hC000, 3'd0, 2'd3},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 16'h0000, 3'd0, 2'd3},
    '{1'b1, 16'hD004, 1'b1, 2'b11, 16'h0000, 3'd1, 2'd3},
    '{1'b1, 16'hE005, 1'b0, 2'b11, 16'hD004, 3'd2, 2'd3},
    '{1'b1, 16'hF006, 1'b0, 2'b11, 16'hD004, 3'd3, 2'd3},
    '{1'b1, 16'h1234, 1'b0, 2'b11, 16'hD004, 3'd4, 2'd3},
    '{1'b1, 16'h5678, 1'b0, 2'b11, 16'hD004, 3'd4, 2'd3},
    '{1'b1, 16'h9ABC, 1'b1, 2'b11, 16'hD004, 3'd4, 2'd0},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 16'hE005, 3'd3, 2'd1},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 16'hF006, 3'd2, 2'd2},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 16'h1234, 3'd1, 2'd3},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 16'h9ABC, 3'd0, 2'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    res_valid    = 1'b0;
    res_data     = '0;
    bus_rd       = 1'b0;
    bus_be       = '0;
    overflow_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; cycles = 0; done = 1'b0;
    idle_inputs();
    drain_en = 1'b0;
    drain_to_dma = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 count", 16'(fill_count), 16'd0);
    chk("R12 head", 16'(head_ptr), 16'd0);
    chk("R12 flags", 16'({has_data, overflow, irq_req, dma_req}), 16'd0);

    // table walk: R1 R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      res_valid = VECS[i].push;
      res_data  = VECS[i].data;
      bus_rd    = VECS[i].rd;
      bus_be    = VECS[i].be;
      #2;
      chk($sformatf("R1/R3/R8 rdata v%0d", i), bus_rdata, VECS[i].exp_rd);
      @(posedge clk);
      #2;
      idle_inputs();
      chk($sformatf("R2/R9 count v%0d", i), 16'(fill_count), 16'(VECS[i].exp_cnt));
      chk($sformatf("R4 head v%0d", i), 16'(head_ptr), 16'(VECS[i].exp_ptr));
      chk($sformatf("R5 has_data v%0d", i), 16'(has_data), 16'(VECS[i].exp_cnt != 3'd0));
    end

    // R6 overflow set by discarded push in the table stays set
    @(negedge clk);
    chk("R6 overflow sticky", 16'(overflow), 16'd1);
    // R7 clear pulse
    overflow_clr = 1'b1;
    @(negedge clk);
    overflow_clr = 1'b0;
    chk("R7 overflow cleared", 16'(overflow), 16'd0);

    // R7 set wins over clear: fill to 4 then push with clear
    for (int k = 0; k < 4; k++) begin
      res_valid = 1'b1; res_data = 16'(16'h4000 + k);
      @(negedge clk);
    end
    overflow_clr = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R7 set wins", 16'(overflow), 16'd1);
    chk("R6 full count", 16'(fill_count), 16'd4);
    bus_be = 2'b11;
    #2;
    chk("R6 dropped push kept oldest", bus_rdata, 16'h4000);
    overflow_clr = 1'b1;
    @(negedge clk);
    idle_inputs();

    // R10 / R11 routing with data present
    chk("R10 no request when disabled", 16'({irq_req, dma_req}), 16'd0);
    drain_en = 1'b1; drain_to_dma = 1'b0;
    #2;
    chk("R11 irq route", 16'({irq_req, dma_req}), 16'b10);
    drain_to_dma = 1'b1;
    #2;
    chk("R11 dma route", 16'({irq_req, dma_req}), 16'b01);

    // drain by single-byte reads until empty
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_rd = 1'b1; bus_be = 2'b10;
      #2;
      chk("R3 byte read lane", bus_rdata, 16'h4000);
    end
    @(negedge clk);
    idle_inputs();
    chk("R3 drained", 16'(fill_count), 16'd0);
    chk("R10 no request when empty", 16'({irq_req, dma_req}), 16'd0);

    // R3 read with no byte enable does not pop
    res_valid = 1'b1; res_data = 16'h77AA;
    @(negedge clk);
    idle_inputs();
    bus_rd = 1'b1; bus_be = 2'b00;
    @(negedge clk);
    idle_inputs();
    chk("R3 zero-enable no pop", 16'(fill_count), 16'd1);

    // R12 reset mid-run clears state
    rst_n = 1'b0;
    #2;
    chk("R12 async clear", 16'(fill_count), 16'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 flags after reset", 16'({has_data, irq_req, dma_req}), 16'd0);

    finish_run();
  end
endmodule